// File: doc/BRIEF.md
# Line-interface parallel control decoder

This block is the host-facing control stage of a telephone line interface. A card controller writes a three-bit operating mode and two test-relay bits over a small parallel bus. The write is qualified by an active-low input select, and the values are held in internal registers once the select goes high. The block decodes the held mode into internal enables: a ringing-relay drive and a reverse-polarity flag. It also selects which detector flag each of the two active-low status lines reports.

The analog detectors sit outside this block and arrive as synchronous digital flags: off-hook, ring-trip, ground-key, longitudinal fault, power-cross and thermal alarm. The two status lines are modelled as a data value plus an output enable, and the enable follows the output select. A reset input and the thermal alarm each push the block into an idle condition, and each idle condition treats the relays and the status lines differently. A ring-trip seen during ringing is held. It drops the ringing relay without waiting for the controller, until a different mode is written.

Top module: `line_ctl_decoder`

## Requirements
- R1: On a rising clock edge where `sel_in_n` is 0, `mode_code` and `test_rly_req` are stored. Outputs reflect the stored values from that edge on. While `sel_in_n` is 1 the stored values do not change.
- R2: `det_oe` and `gk_oe` are 1 exactly when `sel_out_n` is 0, so that both status lines are high-impedance while `sel_out_n` is 1.
- R3: The detection line `det_val` (0 = event) is chosen by the stored code: 0 = power-down, 1 = stand-by, 2 = active normal, 3 = active reverse, 4 = ringing normal, 5 = ringing reverse, 6 = ground start, 7 = high-impedance feed. It reports `hook_flag` for codes 1, 2, 3, 6 and 7, reports the held ring-trip for codes 4 and 5, and stays 1 for code 0.
- R4: `gk_val` (0 = event) reports `gkey_flag` for codes 1, 2, 3 and 6, and stays 1 for codes 0, 4, 5 and 7.
- R5: With code 0 stored, `test_rly` follows the stored relay bits, `ring_rly` is 0, and both status values are 1.
- R6: While `rst_n` is 0, `test_rly`, `ring_rly` and `rev_pol` are 0 and both status values are 1. After reset the stored code and relay bits are 0.
- R7: While `therm_flag` is 1 and `rst_n` is 1, `ring_rly` and `rev_pol` are 0, `test_rly` follows the stored bits, and both status values are 0.
- R8: While `lfault_flag` or `pcross_flag` is 1, with no thermal alarm and a stored code other than 0, both status values are 0. The stored code is unchanged, so normal reporting resumes when the fault clears.
- R9: `ring_rly` is 1 for stored codes 4 and 5 unless a ring-trip is held. A `trip_flag` sampled at an edge while a ringing code is stored sets the hold. The hold keeps `det_val` at 0 and `ring_rly` at 0. It clears only when a different code is written or a non-ringing code is stored. Rewriting the same code keeps it.
- R10: `rev_pol` is 1 for stored codes 3 and 5 when neither reset nor thermal alarm is active, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sel_in_n | input | 1 | Active-low write select for the control bus |
| sel_out_n | input | 1 | Active-low enable for the status lines |
| mode_code | input | 3 | Operating mode code |
| test_rly_req | input | 2 | Test relay requests, 1 = on |
| hook_flag | input | 1 | Off-hook detector |
| trip_flag | input | 1 | Ring-trip detector |
| gkey_flag | input | 1 | Ground-key detector |
| lfault_flag | input | 1 | Longitudinal fault detector |
| pcross_flag | input | 1 | Power-cross over-current detector |
| therm_flag | input | 1 | Thermal alarm |
| test_rly | output | 2 | Test relay drives |
| ring_rly | output | 1 | Ringing relay drive |
| rev_pol | output | 1 | Reverse feed polarity enable |
| det_val | output | 1 | Detection line value, active low |
| det_oe | output | 1 | Detection line output enable |
| gk_val | output | 1 | Ground-key/alarm line value, active low |
| gk_oe | output | 1 | Ground-key/alarm line output enable |

## Verification
The hardest situation to reach is the held ring-trip. It must be set while a ringing code is stored and then survive a rewrite of the same code. It must be cleared by a write of a different code, and it must not be confused with a fault or thermal alarm that pulls the same line low. The stimulus first stores a ringing code and pulses the trip flag for one edge. It then rewrites the identical code, raises and drops a fault, and only then writes a new code, checking the line and the relay at each step.

// File: rtl/line_ctl_pkg.sv
package line_ctl_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    M_OFF    = 3'd0,
    M_SBY    = 3'd1,
    M_ACT_N  = 3'd2,
    M_ACT_R  = 3'd3,
    M_RING_N = 3'd4,
    M_RING_R = 3'd5,
    M_GSTART = 3'd6,
    M_HIFEED = 3'd7
  } mode_e;

  typedef struct packed {
    logic off;
    logic hook_rpt;
    logic trip_rpt;
    logic gkey_rpt;
    logic ringing;
    logic rev;
  } dec_t;
endpackage

// File: rtl/ctl_latch.sv
module ctl_latch #(
  parameter int CODE_W = 3,
  parameter int RLY_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic [RLY_N-1:0]  rly_in,
  output logic [CODE_W-1:0] code_q,
  output logic [RLY_N-1:0]  rly_q,
  output logic              code_chg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      rly_q  <= '0;
    end else if (!sel_n) begin
      code_q <= code_in;
      rly_q  <= rly_in;
    end
  end

  // a write that changes the stored code, seen at the coming edge
  assign code_chg = !sel_n && (code_in != code_q);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> ($stable(code_q) && $stable(rly_q)));
  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |=> (code_q == $past(code_in)));
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import line_ctl_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code,
  output dec_t              dec
);
  always_comb begin
    dec = '0;
    unique case (mode_e'(code))
      M_OFF:    dec.off = 1'b1;
      M_SBY:    begin dec.hook_rpt = 1'b1; dec.gkey_rpt = 1'b1; end
      M_ACT_N:  begin dec.hook_rpt = 1'b1; dec.gkey_rpt = 1'b1; end
      M_ACT_R:  begin dec.hook_rpt = 1'b1; dec.gkey_rpt = 1'b1; dec.rev = 1'b1; end
      M_RING_N: begin dec.trip_rpt = 1'b1; dec.ringing = 1'b1; end
      M_RING_R: begin dec.trip_rpt = 1'b1; dec.ringing = 1'b1; dec.rev = 1'b1; end
      M_GSTART: begin dec.hook_rpt = 1'b1; dec.gkey_rpt = 1'b1; end
      M_HIFEED: dec.hook_rpt = 1'b1;
      default:  dec.off = 1'b1;
    endcase
  end
endmodule

// File: rtl/trip_hold.sv
module trip_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic ringing,
  input  logic trip_flag,
  input  logic code_chg,
  output logic trip_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                trip_q <= 1'b0;
    else if (code_chg)         trip_q <= 1'b0;
    else if (!ringing)         trip_q <= 1'b0;
    else if (trip_flag)        trip_q <= 1'b1;
  end

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |=> !trip_q);
  assert_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ringing && trip_flag && !code_chg) |=> trip_q);
endmodule

// File: rtl/status_mux.sv
module status_mux
  import line_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  dec_t dec,
  input  logic therm,
  input  logic fault,
  input  logic hook,
  input  logic trip_q,
  input  logic gkey,
  input  logic sel_out_n,
  output logic det_val,
  output logic det_oe,
  output logic gk_val,
  output logic gk_oe
);
  always_comb begin
    det_val = 1'b1;
    gk_val  = 1'b1;
    if (!rst_n) begin
      det_val = 1'b1;
      gk_val  = 1'b1;
    end else if (therm || (fault && !dec.off)) begin
      det_val = 1'b0;
      gk_val  = 1'b0;
    end else begin
      if (dec.hook_rpt) det_val = !hook;
      if (dec.trip_rpt) det_val = !trip_q;
      if (dec.gkey_rpt) gk_val  = !gkey;
    end
  end

  assign det_oe = !sel_out_n;
  assign gk_oe  = !sel_out_n;

  assert_alarm_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    therm |-> (!det_val && !gk_val));
  assert_fault_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !dec.off) |-> (!det_val && !gk_val));
  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.off && !therm) |-> (det_val && gk_val));
endmodule

// File: rtl/line_ctl_decoder.sv
module line_ctl_decoder
  import line_ctl_pkg::*;
#(
  parameter int RLY_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_in_n,
  input  logic             sel_out_n,
  input  logic [2:0]       mode_code,
  input  logic [RLY_N-1:0] test_rly_req,
  input  logic             hook_flag,
  input  logic             trip_flag,
  input  logic             gkey_flag,
  input  logic             lfault_flag,
  input  logic             pcross_flag,
  input  logic             therm_flag,
  output logic [RLY_N-1:0] test_rly,
  output logic             ring_rly,
  output logic             rev_pol,
  output logic             det_val,
  output logic             det_oe,
  output logic             gk_val,
  output logic             gk_oe
);
  logic [CODE_W-1:0] code_q;
  logic [RLY_N-1:0]  rly_q;
  logic              code_chg;
  logic              trip_q;
  dec_t              dec;

  ctl_latch #(.CODE_W(CODE_W), .RLY_N(RLY_N)) u_latch (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_in_n),
    .code_in(mode_code), .rly_in(test_rly_req),
    .code_q(code_q), .rly_q(rly_q), .code_chg(code_chg)
  );

  mode_decode #(.CODE_W(CODE_W)) u_dec (.code(code_q), .dec(dec));

  trip_hold u_trip (
    .clk(clk), .rst_n(rst_n), .ringing(dec.ringing),
    .trip_flag(trip_flag), .code_chg(code_chg), .trip_q(trip_q)
  );

  status_mux u_stat (
    .clk(clk), .rst_n(rst_n), .dec(dec), .therm(therm_flag),
    .fault(lfault_flag || pcross_flag), .hook(hook_flag),
    .trip_q(trip_q), .gkey(gkey_flag), .sel_out_n(sel_out_n),
    .det_val(det_val), .det_oe(det_oe), .gk_val(gk_val), .gk_oe(gk_oe)
  );

  assign test_rly = rst_n ? rly_q : '0;
  assign ring_rly = rst_n && !therm_flag && dec.ringing && !trip_q;
  assign rev_pol  = rst_n && !therm_flag && dec.rev;

  assert_hiz_R2: assert property (@(posedge clk)
    sel_out_n |-> (!det_oe && !gk_oe));
  assert_reset_idle_R6: assert property (@(posedge clk)
    !rst_n |-> (test_rly == '0 && !ring_rly && det_val && gk_val));
  assert_alarm_ring_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    therm_flag |-> !ring_rly);
  assert_trip_drops_ring_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !code_chg) |-> (!ring_rly && !det_val));
endmodule

// File: tb/tb_line_ctl_decoder.sv
`timescale 1ns/100ps
module tb_line_ctl_decoder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0, sel_in_n = 1'b1, sel_out_n = 1'b1;
  logic [2:0] mode_code = '0;
  logic [1:0] test_rly_req = '0;
  logic hook_flag = 0, trip_flag = 0, gkey_flag = 0;
  logic lfault_flag = 0, pcross_flag = 0, therm_flag = 0;
  logic [1:0] test_rly;
  logic ring_rly, rev_pol, det_val, det_oe, gk_val, gk_oe;

  line_ctl_decoder dut (.*);

  typedef struct {
    string tag;
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  event chk_ev;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench model of the stored state
  logic [2:0] m_code = '0;
  logic [1:0] m_rly = '0;
  logic       m_trip = 0;

  function automatic logic [7:0] expect_out();
    logic [1:0] r; logic rr, rp, dv, gv;
    logic ringm, hookm, gkm;
    ringm = (m_code == 3'd4) || (m_code == 3'd5);
    hookm = (m_code inside {3'd1, 3'd2, 3'd3, 3'd6, 3'd7});
    gkm   = (m_code inside {3'd1, 3'd2, 3'd3, 3'd6});
    r = 2'b00; rr = 0; rp = 0; dv = 1; gv = 1;
    if (rst_n) begin
      r = m_rly;
      if (therm_flag) begin
        dv = 0; gv = 0;
      end else begin
        rr = ringm && !m_trip;
        rp = (m_code == 3'd3) || (m_code == 3'd5);
        if ((lfault_flag || pcross_flag) && m_code != 3'd0) begin
          dv = 0; gv = 0;
        end else begin
          if (hookm) dv = !hook_flag;
          if (ringm) dv = !m_trip;
          if (gkm)   gv = !gkey_flag;
        end
      end
    end
    return {r, rr, rp, dv, !sel_out_n, gv, !sel_out_n};
  endfunction

  // driver: apply inputs, run one edge, update model, queue expectation
  task automatic step(input string tag, input logic rst, input logic si,
                      input logic so, input logic [2:0] code,
                      input logic [1:0] rq, input logic [5:0] fl);
    item_t it;
    logic ringm;
    @(negedge clk);
    rst_n = rst; sel_in_n = si; sel_out_n = so;
    mode_code = code; test_rly_req = rq;
    {hook_flag, trip_flag, gkey_flag, lfault_flag, pcross_flag, therm_flag} = fl;
    @(posedge clk);
    ringm = (m_code == 3'd4) || (m_code == 3'd5);
    if (!rst) begin
      m_code = '0; m_rly = '0; m_trip = 0;
    end else begin
      if (!si && code != m_code) m_trip = 0;
      else if (!ringm) m_trip = 0;
      else if (trip_flag) m_trip = 1;
      if (!si) begin m_code = code; m_rly = rq; end
    end
    #1;
    it.tag = tag; it.exp = expect_out();
    q.push_back(it);
    -> chk_ev;
    #0.5;
  endtask

  // monitor
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = {test_rly, ring_rly, rev_pol, det_val, det_oe, gk_val, gk_oe};
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  // flag order: hook, trip, gkey, lfault, pcross, therm
  initial begin
    step("R6", 0, 0, 0, 3'd3, 2'b11, 6'b000000);
    step("R6", 0, 1, 0, 3'd0, 2'b00, 6'b101000);
    step("R6", 1, 1, 0, 3'd0, 2'b00, 6'b101000);   // stored state is zero
    step("R5", 1, 0, 0, 3'd0, 2'b10, 6'b101000);
    step("R5", 1, 1, 0, 3'd0, 2'b00, 6'b101000);
    step("R2", 1, 1, 1, 3'd0, 2'b00, 6'b000000);
    // every code with hook and gkey both high and both low
    for (int c = 1; c < 8; c++) begin
      step("R1", 1, 0, 0, c[2:0], 2'b01, 6'b000000);
      step("R3", 1, 1, 0, 3'd0, 2'b00, 6'b100000);
      step("R4", 1, 1, 0, 3'd0, 2'b00, 6'b001000);
      step("R10", 1, 1, 1, 3'd7, 2'b11, 6'b101000);
    end
    step("R1", 1, 1, 0, 3'd2, 2'b10, 6'b000000);    // select high: ignored
    step("R2", 1, 1, 1, 3'd2, 2'b10, 6'b100000);
    // faults and thermal alarm
    step("R1", 1, 0, 0, 3'd1, 2'b11, 6'b000000);
    step("R8", 1, 1, 0, 3'd1, 2'b00, 6'b000100);
    step("R8", 1, 1, 0, 3'd1, 2'b00, 6'b000010);
    step("R8", 1, 1, 0, 3'd1, 2'b00, 6'b001000);    // resumes stand-by
    step("R7", 1, 1, 0, 3'd1, 2'b00, 6'b000001);
    step("R1", 1, 0, 0, 3'd4, 2'b01, 6'b000001);
    step("R7", 1, 1, 0, 3'd4, 2'b00, 6'b000001);
    step("R9", 1, 1, 0, 3'd4, 2'b00, 6'b000000);
    // ring-trip hold
    step("R9", 1, 1, 0, 3'd4, 2'b00, 6'b010000);
    step("R9", 1, 1, 0, 3'd4, 2'b00, 6'b000000);
    step("R9", 1, 0, 0, 3'd4, 2'b01, 6'b000000);    // same code rewrite
    step("R8", 1, 1, 0, 3'd4, 2'b00, 6'b000100);
    step("R9", 1, 1, 0, 3'd4, 2'b00, 6'b000000);
    step("R9", 1, 0, 0, 3'd5, 2'b01, 6'b000000);    // new code clears
    step("R10", 1, 1, 0, 3'd5, 2'b00, 6'b000000);
    step("R9", 1, 1, 0, 3'd5, 2'b00, 6'b010000);
    step("R9", 1, 0, 0, 3'd2, 2'b00, 6'b010000);
    step("R9", 1, 0, 0, 3'd4, 2'b00, 6'b000000);
    step("R5", 1, 0, 0, 3'd0, 2'b11, 6'b000100);    // fault in power-down
    step("R5", 1, 1, 0, 3'd0, 2'b00, 6'b000110);
    step("R6", 0, 1, 0, 3'd0, 2'b00, 6'b000000);
    step("R6", 1, 1, 0, 3'd0, 2'b00, 6'b000000);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule